// File: doc/BRIEF.md
# Triple-Sample Counter Read Filter

This block sits in the reader's clock domain and returns a reliable value from a free-running counter that runs on an unrelated clock. A plain single capture of such a counter can catch some bits mid-transition. The captured word can then be far from any value the counter ever held.

When a read is requested, the filter captures the raw counter bus on three back-to-back reader clock edges. It treats at most one of the three captures as suspect. From the captures that agree within one count, it picks a result. It then pulses a completion strobe. If no two captures agree, it raises an error flag beside the result.

The method is sound only if the counting clock's shortest period is longer than three reader cycles. The requester must guarantee this.

Top module: `tri_sample_filter`

## Requirements
- R1: While reset is held, and after it is released until the first completed read, `val_out` is zero, `done` is 0 and `err` is 0.
- R2: A request seen on rising edge N starts a read. The raw bus is captured on edges N, N+1 and N+2. `done` is then high for exactly one cycle, the cycle that follows edge N+3.
- R3: If capture 1 and capture 2 are within one count of each other, the result is capture 2.
- R4: Otherwise, if capture 2 and capture 3 are within one count, the result is capture 3.
- R5: Otherwise, if capture 1 and capture 3 are within one count, the result is capture 3.
- R6: If no pair is within one count, the result is capture 3 and `err` is 1. In every other case `err` is 0. `err` is updated on the same edge as the result.
- R7: Distance is measured modulo 2^WIDTH, so the all-ones value and zero count as adjacent.
- R8: A request seen on edges N+1 to N+3 of an ongoing read is ignored and produces no extra `done`.
- R9: `val_out` and `err` change only on the edge that raises `done`. Between reads they hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reader clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| req | input | 1 | Read request, sampled on the rising edge |
| cnt_raw | input | WIDTH | Raw counter bus from the other clock domain |
| val_out | output | WIDTH | Filtered counter value |
| done | output | 1 | One-cycle strobe marking a new result |
| err | output | 1 | No pair of captures agreed within one count |

## Verification
The bench feeds capture triples that reach each branch of the selection order. One triple lets only the first and third captures agree, as a torn 0x8000 to 0x7FFF step does; a filter that stops after two comparisons would return the torn middle word. Another triple straddles the wrap from all-ones to zero; plain unsigned subtraction without wrap would flag it as an error. The bench also raises `req` again during a read. A filter that restarts or queues would emit a second strobe, or would build its result from the wrong captures. Finally, it moves the bus between reads to catch an output that follows the input instead of holding.

// File: rtl/tri_sample_filter.sv
module tri_sample_filter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [WIDTH-1:0] cnt_raw,
  output logic [WIDTH-1:0] val_out,
  output logic             done,
  output logic             err
);
  localparam logic [WIDTH-1:0] STEP_UP = WIDTH'(1);
  localparam logic [WIDTH-1:0] STEP_DN = '1;

  logic [1:0]       phase;
  logic [WIDTH-1:0] s1, s2, s3;
  logic [WIDTH-1:0] pick;
  logic             bad;

  function automatic logic near(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] d;
    d = a - b;
    return (d == '0) || (d == STEP_UP) || (d == STEP_DN);
  endfunction

  wire n12 = near(s1, s2);
  wire n23 = near(s2, s3);
  wire n13 = near(s1, s3);

  assign pick = n12 ? s2 : s3;
  assign bad  = !(n12 || n23 || n13);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= 2'd0;
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
      val_out <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        2'd0: if (req) begin
          s1    <= cnt_raw;
          phase <= 2'd1;
        end
        2'd1: begin
          s2    <= cnt_raw;
          phase <= 2'd2;
        end
        2'd2: begin
          s3    <= cnt_raw;
          phase <= 2'd3;
        end
        default: begin
          val_out <= pick;
          err     <= bad;
          done    <= 1'b1;
          phase   <= 2'd0;
        end
      endcase
    end
  end
endmodule

module tri_sample_filter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic [WIDTH-1:0] cnt_raw,
  input logic [WIDTH-1:0] val_out,
  input logic             done,
  input logic             err
);
  function automatic logic close1(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    return (a == b) || (a + WIDTH'(1) == b) || (b + WIDTH'(1) == a);
  endfunction

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(req, 4));
  // R8
  done_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!$past(done) && !$past(done, 2) && !$past(done, 3)));
  // R9
  hold_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(val_out) && $stable(err)));
  // R6
  err_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (val_out == $past(cnt_raw, 2)));
  // R3
  first_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && close1($past(cnt_raw, 4), $past(cnt_raw, 3))) |-> (!err && val_out == $past(cnt_raw, 3)));
endmodule

bind tri_sample_filter tri_sample_filter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .cnt_raw(cnt_raw),
  .val_out(val_out), .done(done), .err(err)
);

// File: tb/tri_sample_filter_test.sv
`timescale 1ns/1ps
module tri_sample_filter_test;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic [WIDTH-1:0] cnt_raw = '0;
  logic [WIDTH-1:0] val_out;
  logic             done;
  logic             err;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] exp_val_q[$];
  logic             exp_err_q[$];
  string            exp_tag_q[$];
  logic [WIDTH-1:0] last_val = '0;
  logic             last_err = 1'b0;
  logic             mon_on = 1'b0;
  logic             prev_done = 1'b0;

  tri_sample_filter #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cnt_raw(cnt_raw),
    .val_out(val_out), .done(done), .err(err)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        check(!prev_done, "R2 done wider than one cycle", 32'(done), 32'(0));
        if (exp_val_q.size() == 0) begin
          check(1'b0, "R8 unexpected done", 32'(val_out), 32'(0));
        end else begin
          automatic logic [WIDTH-1:0] ev = exp_val_q.pop_front();
          automatic logic             ee = exp_err_q.pop_front();
          automatic string            tg = exp_tag_q.pop_front();
          check(val_out == ev, {tg, " value"}, 32'(val_out), 32'(ev));
          check(err == ee, {tg, " err"}, 32'(err), 32'(ee));
          last_val = ev;
          last_err = ee;
        end
      end else begin
        check(val_out == last_val && err == last_err, "R9 outputs held",
              {15'd0, err, val_out}, {15'd0, last_err, last_val});
      end
      prev_done = done;
    end
  end

  task automatic do_read(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic [WIDTH-1:0] c, input logic [WIDTH-1:0] ev,
                         input logic ee, input string tg, input bit poke);
    exp_val_q.push_back(ev);
    exp_err_q.push_back(ee);
    exp_tag_q.push_back(tg);
    @(negedge clk); req = 1'b1; cnt_raw = a;
    @(negedge clk); req = poke; cnt_raw = b;
    @(negedge clk); req = poke; cnt_raw = c;
    @(negedge clk); req = poke; cnt_raw = ~c;
    @(negedge clk); req = 1'b0; cnt_raw = a ^ 16'h5a5a;
    @(negedge clk); cnt_raw = b ^ 16'h0f0f;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(val_out == '0 && !done && !err, "R1 reset state", {15'd0, err, val_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(val_out == '0 && !done && !err, "R1 after release", {15'd0, err, val_out}, 32'd0);
    mon_on = 1'b1;

    do_read(16'd100, 16'd101, 16'd5,    16'd101,  1'b0, "R3 first pair", 1'b0);
    do_read(16'd42,  16'd42,  16'd42,   16'd42,   1'b0, "R3 equal", 1'b0);
    do_read(16'd7,   16'd50,  16'd51,   16'd51,   1'b0, "R4 second pair", 1'b0);
    do_read(16'd7,   16'd900, 16'd8,    16'd8,    1'b0, "R5 outer pair", 1'b0);
    do_read(16'h8000, 16'hFFFF, 16'h7FFF, 16'h7FFF, 1'b0, "R5 torn step", 1'b0);
    do_read(16'd1,   16'd1000, 16'd5000, 16'd5000, 1'b1, "R6 no pair", 1'b0);
    do_read(16'd9,   16'd10,  16'd300,  16'd10,   1'b0, "R6 err clears", 1'b0);
    do_read(16'hFFFF, 16'h0000, 16'h4444, 16'h0000, 1'b0, "R7 wrap up", 1'b0);
    do_read(16'h3000, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b0, "R7 wrap down", 1'b0);
    do_read(16'd20,  16'd21,  16'd21,   16'd21,   1'b0, "R8 pokes ignored", 1'b1);
    do_read(16'd500, 16'd60,  16'd61,   16'd61,   1'b0, "R8 poke second pair", 1'b1);

    repeat (6) @(negedge clk);
    check(exp_val_q.size() == 0, "R2 every read completed", 32'(exp_val_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule